// File: doc/BRIEF.md
# Vector Loop Sequencer with Scalar Operand Capture

This block steps through the element operations of one vector instruction. It behaves as a hardware loop over element indices, starting at a start index and stopping before the vector length. When an instruction starts from index zero, the block first copies the instruction's scalar and subvector source operands into a bank of saved-state slots. Every element it emits then takes its operands from that copy, not from the live source registers. A destination register that overlaps a scalar source therefore cannot change the operands that later elements see. The copy is also forwarded to element zero in the same cycle it is written, so the capture step costs no cycle.

An instruction that resumes with a non-zero start index skips the capture step and reads the slots saved earlier. An interrupt that arrives while an element is being accepted parks the loop. The index of the next element is kept as the start index, so the saved slots and that index together are the whole context to save and restore. A small state port can read and write every slot and the start index while the loop is idle.

Top module: `vloop_capture`

## Requirements
- R1: After reset the block is idle: issueReady is 1, busy, elemValid and done are 0, and every saved slot and the start index read back as zero.
- R2: An issue is accepted in any cycle where issueValid and issueReady are both 1. When the accepted start index is zero, each slot whose issueMask bit is 1 takes the live operand. Slots whose mask bit is 0 keep their previous contents.
- R3: An issue with start index zero and non-zero length offers element 0 (elemValid=1, elemIdx=0) in the issue cycle itself. Its slot fields carry the live operand for masked slots and the saved value for the others.
- R4: Elements after the issue cycle carry the captured slot values, even if the live operand inputs change after the issue.
- R5: An issue with a non-zero start index writes no slot. Elements from that index up to length-1 carry the previously saved values, starting in the cycle after the issue.
- R6: While elemValid is 1 and elemReady is 0, elemValid stays 1 and elemIdx and elemOps hold their values.
- R7: If irqReq is 1 when a non-last element completes its handshake, busy is 0 from the next cycle and done is not raised. The start index then reads back as that element's index plus one, and the saved slots are unchanged.
- R8: A handshake on element length-1 ends the loop. The start index reads back as zero and done is 1 for exactly the following cycle.
- R9: An issue whose start index is equal to or greater than its length emits no element, raises done in the next cycle and clears the start index.
- R10: State port address s (0..NUM_SLOTS-1) selects slot s and address NUM_SLOTS selects the start index, zero-extended. Reads are combinational. A write takes effect at the clock edge only when the block is idle and no issue is accepted in that cycle; any other write is ignored.
- R11: Each element handshake that does not end the loop makes the next offered element index one greater.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request |
| issueReady | output | 1 | Block idle, can accept an issue |
| issueVl | input | VL_W | Vector length |
| issueVstart | input | VL_W | Start index |
| issueMask | input | NUM_SLOTS | Scalar operand slot valid mask |
| issueOps | input | NUM_SLOTS*SLOT_W | Live scalar operand values, slot s at bits [s*SLOT_W +: SLOT_W] |
| elemValid | output | 1 | Element offered |
| elemReady | input | 1 | Element accepted by downstream |
| elemIdx | output | VL_W | Element index |
| elemOps | output | NUM_SLOTS*SLOT_W | Scalar operands for the element |
| irqReq | input | 1 | Interrupt request |
| stAddr | input | ADDR_W | State port address |
| stWrEn | input | 1 | State port write enable |
| stWrData | input | SLOT_W | State port write data |
| stRdData | output | SLOT_W | State port read data |
| busy | output | 1 | Loop running |
| done | output | 1 | One-cycle instruction completion pulse |

## Verification
The bench sweeps every length and start index of a small configuration, including start indices past the length, under several ready-stall patterns and with interrupts placed on different elements. The live operands are scrambled after each issue and junk state-port writes are driven during every instruction. A design that read live registers would then emit wrong operands on elements after the first. A design that did not gate port writes would corrupt slots or the start index. If capture were not forwarded, element zero would go missing or carry stale values in the issue cycle. Wrong interrupt handling shows up as a wrong start index on readback, and a missing empty-loop case shows up as a hang or a missing done pulse.

// File: rtl/vloop_pkg.sv
package vloop_pkg;

  // strobes from the sequencer to the slot datapath
  typedef struct packed {
    logic capture;   // write masked slots from live operands
    logic fwdLive;   // present live operands on masked slots this cycle
    logic portWr;    // state port write permitted
  } seqStrobes_t;

endpackage

// File: rtl/vloop_dpath.sv
module vloop_dpath
  import vloop_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W = 64,
  parameter int VL_W = 8,
  parameter int ADDR_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqStrobes_t                 strb,
  input  logic [NUM_SLOTS-1:0]        issueMask,
  input  logic [NUM_SLOTS*SLOT_W-1:0] issueOps,
  input  logic [ADDR_W-1:0]           stAddr,
  input  logic [SLOT_W-1:0]           stWrData,
  input  logic [VL_W-1:0]             vstartVal,
  output logic [NUM_SLOTS*SLOT_W-1:0] elemOps,
  output logic [SLOT_W-1:0]           stRdData
);

  logic [SLOT_W-1:0] slotQ [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [SLOT_W-1:0] liveOp;
    assign liveOp = issueOps[s*SLOT_W +: SLOT_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotQ[s] <= '0;
      end else if (strb.capture && issueMask[s]) begin
        slotQ[s] <= liveOp;
      end else if (strb.portWr && stAddr == ADDR_W'(s)) begin
        slotQ[s] <= stWrData;
      end
    end

    // operand select: live value while capturing, saved copy otherwise
    assign elemOps[s*SLOT_W +: SLOT_W] =
      (strb.fwdLive && issueMask[s]) ? liveOp : slotQ[s];
  end

  always_comb begin
    stRdData = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (stAddr == ADDR_W'(s)) stRdData = slotQ[s];
    end
    if (stAddr == ADDR_W'(NUM_SLOTS)) stRdData[VL_W-1:0] = vstartVal;
  end

endmodule

// File: rtl/vloop_seq.sv
module vloop_seq
  import vloop_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int VL_W = 8,
  parameter int ADDR_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [VL_W-1:0]   issueVl,
  input  logic [VL_W-1:0]   issueVstart,
  input  logic              elemReady,
  input  logic              irqReq,
  input  logic              stWrEn,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [VL_W-1:0]   stWrVstart,
  output logic              issueReady,
  output logic              elemValid,
  output logic [VL_W-1:0]   elemIdx,
  output logic              busy,
  output logic              done,
  output logic [VL_W-1:0]   vstartVal,
  output seqStrobes_t       strb
);

  logic            runQ;
  logic            doneQ;
  logic [VL_W-1:0] idxQ;
  logic [VL_W-1:0] vlQ;
  logic [VL_W-1:0] vstartQ;

  logic            issueFire;
  logic            fwdFirst;
  logic            emptyIssue;
  logic            handshake;
  logic            lastElem;
  logic [VL_W-1:0] curVl;
  logic [VL_W-1:0] nextIdx;

  always_comb begin
    issueFire  = !runQ && issueValid;
    fwdFirst   = issueFire && (issueVstart == '0) && (issueVl != '0);
    emptyIssue = issueFire && (issueVstart >= issueVl);
    elemValid  = runQ || fwdFirst;
    elemIdx    = runQ ? idxQ : '0;
    curVl      = runQ ? vlQ : issueVl;
    handshake  = elemValid && elemReady;
    lastElem   = (elemIdx == VL_W'(curVl - 1'b1));
    nextIdx    = VL_W'(elemIdx + 1'b1);

    strb.capture = issueFire && (issueVstart == '0);
    strb.fwdLive = fwdFirst;
    strb.portWr  = stWrEn && !runQ && !issueFire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      doneQ   <= 1'b0;
      idxQ    <= '0;
      vlQ     <= '0;
      vstartQ <= '0;
    end else begin
      doneQ <= 1'b0;
      if (issueFire) vlQ <= issueVl;
      if (handshake) begin
        if (lastElem) begin
          runQ    <= 1'b0;
          vstartQ <= '0;
          doneQ   <= 1'b1;
        end else if (irqReq) begin
          runQ    <= 1'b0;
          vstartQ <= nextIdx;
        end else begin
          runQ <= 1'b1;
          idxQ <= nextIdx;
        end
      end else if (issueFire) begin
        if (emptyIssue) begin
          vstartQ <= '0;
          doneQ   <= 1'b1;
        end else begin
          runQ    <= 1'b1;
          idxQ    <= issueVstart;
          vstartQ <= issueVstart;
        end
      end else if (strb.portWr && stAddr == ADDR_W'(NUM_SLOTS)) begin
        vstartQ <= stWrVstart;
      end
    end
  end

  assign issueReady = !runQ;
  assign busy       = runQ;
  assign done       = doneQ;
  assign vstartVal  = vstartQ;

endmodule

// File: rtl/vloop_capture.sv
module vloop_capture
  import vloop_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W = 64,
  parameter int VL_W = 8,
  localparam int ADDR_W = $clog2(NUM_SLOTS + 1),
  localparam int OPS_W = NUM_SLOTS * SLOT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  output logic                 issueReady,
  input  logic [VL_W-1:0]      issueVl,
  input  logic [VL_W-1:0]      issueVstart,
  input  logic [NUM_SLOTS-1:0] issueMask,
  input  logic [OPS_W-1:0]     issueOps,
  output logic                 elemValid,
  input  logic                 elemReady,
  output logic [VL_W-1:0]      elemIdx,
  output logic [OPS_W-1:0]     elemOps,
  input  logic                 irqReq,
  input  logic [ADDR_W-1:0]    stAddr,
  input  logic                 stWrEn,
  input  logic [SLOT_W-1:0]    stWrData,
  output logic [SLOT_W-1:0]    stRdData,
  output logic                 busy,
  output logic                 done
);

  seqStrobes_t     strb;
  logic [VL_W-1:0] vstartVal;

  vloop_seq #(.NUM_SLOTS(NUM_SLOTS), .VL_W(VL_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueVl(issueVl), .issueVstart(issueVstart),
    .elemReady(elemReady), .irqReq(irqReq),
    .stWrEn(stWrEn), .stAddr(stAddr), .stWrVstart(stWrData[VL_W-1:0]),
    .issueReady(issueReady), .elemValid(elemValid), .elemIdx(elemIdx),
    .busy(busy), .done(done), .vstartVal(vstartVal), .strb(strb)
  );

  vloop_dpath #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .VL_W(VL_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .issueMask(issueMask), .issueOps(issueOps),
    .stAddr(stAddr), .stWrData(stWrData), .vstartVal(vstartVal),
    .elemOps(elemOps), .stRdData(stRdData)
  );

endmodule

// File: rtl/vloop_chk.sv
module vloop_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W = 64,
  parameter int VL_W = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        issueValid,
  input logic                        elemValid,
  input logic                        elemReady,
  input logic [VL_W-1:0]             elemIdx,
  input logic [NUM_SLOTS*SLOT_W-1:0] elemOps,
  input logic                        irqReq,
  input logic                        busy,
  input logic                        done
);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    elemValid && !elemReady |=> elemValid && $stable(elemIdx) && $stable(elemOps));

  // R7
  irq_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && elemValid && elemReady && irqReq |=> !busy);

  // R11
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && elemValid && elemReady && !irqReq |=>
      !busy || elemIdx == VL_W'($past(elemIdx) + 1'b1));

  // R3
  fwd_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    elemValid && !busy |-> issueValid && elemIdx == '0);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind vloop_capture vloop_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .VL_W(VL_W)) u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .elemValid(elemValid),
  .elemReady(elemReady), .elemIdx(elemIdx), .elemOps(elemOps),
  .irqReq(irqReq), .busy(busy), .done(done)
);

// File: tb/test_vloop_capture.sv
module test_vloop_capture;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int SW = 16;
  localparam int VW = 4;
  localparam int AW = $clog2(NS + 1);
  localparam int OW = NS * SW;

  logic clk = 0;
  logic rstN = 0;
  logic issueValid = 0, issueReady;
  logic [VW-1:0] issueVl = '0, issueVstart = '0;
  logic [NS-1:0] issueMask = '0;
  logic [OW-1:0] issueOps = '0;
  logic elemValid, elemReady = 0;
  logic [VW-1:0] elemIdx;
  logic [OW-1:0] elemOps;
  logic irqReq = 0;
  logic [AW-1:0] stAddr = '0;
  logic stWrEn = 0;
  logic [SW-1:0] stWrData = '0, stRdData;
  logic busy, done;

  int checks = 0;
  int fails = 0;
  logic [SW-1:0] mdl [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  vloop_capture #(.NUM_SLOTS(NS), .SLOT_W(SW), .VL_W(VW)) i_vloop_capture (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
    .issueVl(issueVl), .issueVstart(issueVstart), .issueMask(issueMask),
    .issueOps(issueOps), .elemValid(elemValid), .elemReady(elemReady),
    .elemIdx(elemIdx), .elemOps(elemOps), .irqReq(irqReq), .stAddr(stAddr),
    .stWrEn(stWrEn), .stWrData(stWrData), .stRdData(stRdData),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] mdlFlat();
    logic [OW-1:0] f;
    for (int s = 0; s < NS; s++) f[s*SW +: SW] = mdl[s];
    return f;
  endfunction

  task automatic portWrite(input int a, input logic [SW-1:0] d);
    @(negedge clk);
    stWrEn = 1; stAddr = AW'(a); stWrData = d;
    @(negedge clk);
    stWrEn = 0;
  endtask

  task automatic checkState(input int expVs, input string vsTag, input string slotTag);
    stAddr = AW'(NS); #1;
    chk(stRdData == SW'(expVs), vsTag, 64'(stRdData), 64'(expVs));
    for (int s = 0; s < NS; s++) begin
      stAddr = AW'(s); #1;
      chk(stRdData == mdl[s], slotTag, 64'(stRdData), 64'(mdl[s]));
    end
  endtask

  task automatic runOp(input int vl, input int vs, input int mask, input int seed,
                       input int stall, input int irqAt);
    logic [OW-1:0] live;
    int e, cyc, expVs;
    bit fin, expDone, fwd, rdy, rdyPrev;
    for (int s = 0; s < NS; s++) live[s*SW +: SW] = SW'(seed * 37 + s * 11 + 1);
    @(negedge clk);
    issueValid = 1; issueVl = VW'(vl); issueVstart = VW'(vs);
    issueMask = NS'(mask); issueOps = live;
    stWrEn = 1; stAddr = '0; stWrData = '1;   // junk write, must be ignored (R10)
    rdy = !stall[0]; elemReady = rdy; irqReq = (vs == irqAt);
    #1;
    chk(issueReady == 1, "R2", 64'(issueReady), 64'd1);
    if (vs == 0)
      for (int s = 0; s < NS; s++) if (mask[s]) mdl[s] = live[s*SW +: SW];
    fwd = (vs == 0) && (vl > 0);
    chk(elemValid == fwd, "R3", 64'(elemValid), 64'(fwd));
    if (fwd) begin
      chk(elemIdx == 0, "R3", 64'(elemIdx), 64'd0);
      chk(elemOps == mdlFlat(), "R3", 64'(elemOps), 64'(mdlFlat()));
    end
    e = vs; fin = 0; expDone = 0; expVs = 0;
    if (vs >= vl) begin fin = 1; expDone = 1; end
    @(posedge clk);
    if (fwd && rdy) begin
      if (e == vl - 1) begin fin = 1; expDone = 1; expVs = 0; end
      else if (irqAt == e) begin fin = 1; expVs = e + 1; end
      else e++;
    end
    rdyPrev = rdy;
    cyc = 1;
    while (!fin) begin
      @(negedge clk);
      issueValid = 0; issueOps = ~live;
      stAddr = AW'(cyc % (NS + 1)); stWrData = SW'(cyc * 97 + 5);
      rdy = !stall[cyc % 8]; elemReady = rdy; irqReq = (e == irqAt);
      #1;
      chk(elemValid == 1, "R4", 64'(elemValid), 64'd1);
      chk(elemIdx == VW'(e), "R11", 64'(elemIdx), 64'(e));
      chk(elemOps == mdlFlat(), !rdyPrev ? "R6" : (vs == 0 ? "R4" : "R5"),
          64'(elemOps), 64'(mdlFlat()));
      @(posedge clk);
      if (rdy) begin
        if (e == vl - 1) begin fin = 1; expDone = 1; expVs = 0; end
        else if (irqAt == e) begin fin = 1; expVs = e + 1; end
        else e++;
      end
      rdyPrev = rdy;
      cyc++;
    end
    @(negedge clk);
    issueValid = 0; stWrEn = 0; elemReady = 0; irqReq = 0;
    #1;
    chk(done == expDone, expDone ? (vs >= vl ? "R9" : "R8") : "R7", 64'(done), 64'(expDone));
    chk(busy == 0, "R7", 64'(busy), 64'd0);
    @(negedge clk); #1;
    chk(done == 0, "R8", 64'(done), 64'd0);
    checkState(expVs, expDone ? (vs >= vl ? "R9" : "R8") : "R7", "R10");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) mdl[s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1; #1;
    // R1 reset state
    chk(issueReady == 1, "R1", 64'(issueReady), 64'd1);
    chk(elemValid == 0, "R1", 64'(elemValid), 64'd0);
    chk(busy == 0, "R1", 64'(busy), 64'd0);
    chk(done == 0, "R1", 64'(done), 64'd0);
    checkState(0, "R1", "R1");

    // R10 idle writes to every slot and the start index
    for (int s = 0; s < NS; s++) begin
      portWrite(s, SW'(16'h1000 + s * 16'h0101));
      mdl[s] = SW'(16'h1000 + s * 16'h0101);
    end
    portWrite(NS, SW'(7));
    #1;
    checkState(7, "R10", "R10");
    portWrite(NS, SW'(0));

    // sweep lengths, start indices, masks, stalls and interrupt points
    for (int vl = 0; vl <= 6; vl++) begin
      for (int vs = 0; vs <= vl + 1; vs++) begin
        for (int k = 0; k < 2; k++) begin
          int stall, irqAt;
          stall = ((vl + vs + k) % 3 == 0) ? 8'h00 : (((vl + vs + k) % 3 == 1) ? 8'h5A : 8'h33);
          irqAt = (k == 1 && vs + 1 < vl - 1) ? vs + 1 : -1;
          runOp(vl, vs, (vl * 5 + vs * 3 + k * 7 + 1) & 15, vl * 16 + vs * 2 + k, stall, irqAt);
        end
      end
    end

    // interrupt then resume from the stored start index
    runOp(6, 0, 15, 200, 8'h00, 2);
    runOp(6, 3, 0, 201, 8'h24, -1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule